// File: doc/BRIEF.md
# I2C Bus Timing Monitor

A passive observer for a two-wire serial bus. It samples the clock line and the data line with the system clock and counts how long each line holds a level. It recognises start, repeated start and stop conditions from those levels. Each measured interval is compared with the minimum that the current speed class allows. The block never drives the bus. It is meant to sit beside a bus in a larger design, or in a test environment, and report timing abuse by any master or slave.

Two limit sets are built in: one for the 400 kHz class and one for the 3.4 MHz class. A mode input selects between them. Every limit is given in nanoseconds and turned into a whole number of system clock cycles, rounded up, from the clock period parameter. Seven rules are checked. Each one has a bit in a sticky status vector and a bit in a one-cycle event vector. Edge rates are analog quantities and are not measured.

Top module: `i2c_timing_monitor`

## Requirements
- R1: After reset, both `viol_sticky_o` and `viol_pulse_o` are all zero and stay zero while both lines idle high.
- R2: Bit 0 (clock low) is flagged at an SCL rise when SCL was low for fewer cycles than the low limit (1300 ns in fast mode, 160 ns in high-speed mode).
- R3: Bit 1 (clock high) is flagged at an SCL fall when SCL was high for fewer cycles than the high limit (600 ns fast, 60 ns high-speed).
- R4: A start is an SDA fall, and a stop is an SDA rise, in a sample where SCL is high in both this sample and the one before. Bit 2 (bus free) is flagged at a start that follows a stop when SDA was high since that stop for fewer cycles than 600 ns (fast) or 160 ns (high-speed). A repeated start is never checked for this rule.
- R5: Bit 3 (start hold) is flagged at the first SCL fall after a start or repeated start when SDA had been low since that start for fewer cycles than 100 ns.
- R6: Bit 4 (start setup) is flagged at a start or repeated start when SCL had been high for fewer cycles than 100 ns.
- R7: Bit 5 (stop setup) is flagged at a stop when SCL had been high for fewer cycles than 100 ns.
- R8: Bit 6 (data setup) is flagged at an SCL rise when SDA had been stable for fewer cycles than 100 ns (fast) or 10 ns (high-speed). An SDA change in the same sample as the SCL rise counts as zero setup.
- R9: `hs_mode_i` = 1 selects the high-speed limits and 0 the fast limits. It must only change while the bus is idle.
- R10: A sticky bit stays set until `clr_i` is sampled high. That cycle clears all sticky bits except those of violations raised in the same cycle.
- R11: Each violation gives a pulse exactly one cycle wide on its `viol_pulse_o` bit. The pulse appears on the third rising clock edge, counting the edge that first samples the offending pin levels.
- R12: Interval counters saturate instead of wrapping, so an arbitrarily long level never raises a violation.
- R13: An interval of N samples meets a limit of T ns when N >= ceil(T / clock period). At 20 ns this gives 65/30/30/5/5/5/5 cycles in fast mode and 8/3/8/5/5/5/1 cycles in high-speed mode, in bit order 0, 1, 2, 3, 4, 5, 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; sets the measurement resolution |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| hs_mode_i | input | 1 | 1 selects high-speed limits, 0 fast limits |
| clr_i | input | 1 | Clears the sticky violation vector |
| viol_sticky_o | output | 7 | Accumulated violations, one bit per rule |
| viol_pulse_o | output | 7 | One-cycle flag per new violation |

## Verification
The in-design assertions watch the following on every cycle:
- a pulse is always mirrored in the sticky vector;
- a clear leaves only same-cycle violations, and otherwise sticky bits never drop;
- a saturated counter holds its value;
- the clock-low violation appears only at an SCL rise;
- the hold violation appears only while a start is pending;
- the bus-free violation appears only after a stop.

The exact cycle thresholds can only be shown by the bench scenarios. These scenarios cover:
- frames driven at exactly the rounded limits, and one cycle short of them, in both modes;
- data changing in the same sample as the clock rise;
- repeated starts that must not trigger the bus-free rule;
- levels held far beyond the counter range.

// File: rtl/i2c_tmon_pkg.sv
package i2c_tmon_pkg;

  localparam int NV    = 7;
  localparam int LIM_W = 16;

  // Violation bit positions
  localparam int V_LOW  = 0;
  localparam int V_HIGH = 1;
  localparam int V_FREE = 2;
  localparam int V_HOLD = 3;
  localparam int V_RSU  = 4;
  localparam int V_PSU  = 5;
  localparam int V_DSU  = 6;

  // Line indices
  localparam int SCL = 0;
  localparam int SDA = 1;

  localparam int unsigned FS_LOW_NS  = 1300;
  localparam int unsigned FS_HIGH_NS = 600;
  localparam int unsigned FS_FREE_NS = 600;
  localparam int unsigned FS_DSU_NS  = 100;
  localparam int unsigned HS_LOW_NS  = 160;
  localparam int unsigned HS_HIGH_NS = 60;
  localparam int unsigned HS_FREE_NS = 160;
  localparam int unsigned HS_DSU_NS  = 10;
  localparam int unsigned COND_NS    = 100;

  typedef struct packed {
    logic [LIM_W-1:0] lo;
    logic [LIM_W-1:0] hi;
    logic [LIM_W-1:0] free;
    logic [LIM_W-1:0] hold_sta;
    logic [LIM_W-1:0] setup_sta;
    logic [LIM_W-1:0] setup_sto;
    logic [LIM_W-1:0] setup_dat;
  } limits_t;

  // Nanoseconds to clock cycles, rounded up
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned ps);
    return (ns * 32'd1000 + ps - 32'd1) / ps;
  endfunction

  function automatic limits_t make_limits(input logic hs, input int unsigned ps);
    limits_t l;
    l.lo        = LIM_W'(ns2cyc(hs ? HS_LOW_NS  : FS_LOW_NS,  ps));
    l.hi        = LIM_W'(ns2cyc(hs ? HS_HIGH_NS : FS_HIGH_NS, ps));
    l.free      = LIM_W'(ns2cyc(hs ? HS_FREE_NS : FS_FREE_NS, ps));
    l.hold_sta  = LIM_W'(ns2cyc(COND_NS, ps));
    l.setup_sta = LIM_W'(ns2cyc(COND_NS, ps));
    l.setup_sto = LIM_W'(ns2cyc(COND_NS, ps));
    l.setup_dat = LIM_W'(ns2cyc(hs ? HS_DSU_NS : FS_DSU_NS, ps));
    return l;
  endfunction

endpackage

// File: rtl/i2c_tmon_sync.sv
module i2c_tmon_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    for (genvar g = 0; g < W; g++) begin : g_line
      logic [STAGES-1:0] sh_q;
      logic [STAGES-1:0] sh_d;

      always_comb sh_d = {sh_q[STAGES-2:0], d_i[g]};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
      end

      assign q_o[g] = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_tmon_run.sv
module i2c_tmon_run #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  output logic             edge_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic [CNT_W-1:0] run_o
);

  localparam logic [CNT_W-1:0] RUN_MAX = '1;

  logic             prev_q;
  logic [CNT_W-1:0] run_q, run_d;
  logic             run_en;

  always_comb begin
    edge_o = lvl_i ^ prev_q;
    rise_o = edge_o & lvl_i;
    fall_o = edge_o & ~lvl_i;
    run_en = edge_o | (run_q != RUN_MAX);
    run_d  = edge_o ? CNT_W'(1) : run_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      run_q  <= RUN_MAX;
    end else begin
      prev_q <= lvl_i;
      if (run_en) run_q <= run_d;
    end
  end

  assign run_o = run_q;

  // R12
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_o && run_q == RUN_MAX) |=> (run_q == RUN_MAX));

endmodule

// File: rtl/i2c_tmon_rules.sv
module i2c_tmon_rules
  import i2c_tmon_pkg::*;
#(
  parameter int      CNT_W  = 8,
  parameter limits_t LIM_FS = '0,
  parameter limits_t LIM_HS = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hs_mode_i,
  input  logic                  scl_lvl_i,
  input  logic [1:0]            edge_i,
  input  logic [1:0]            rise_i,
  input  logic [1:0]            fall_i,
  input  logic [1:0][CNT_W-1:0] run_i,
  output logic [NV-1:0]         hits_o
);

  limits_t          lim;
  logic [LIM_W-1:0] scl_len, sda_len, dsu_len;
  logic             scl_hi_stable, start, stop;
  logic             free_q, free_d, pend_q, pend_d, st_en;

  always_comb begin
    lim           = hs_mode_i ? LIM_HS : LIM_FS;
    scl_len       = LIM_W'(run_i[SCL]);
    sda_len       = LIM_W'(run_i[SDA]);
    dsu_len       = edge_i[SDA] ? '0 : sda_len;
    scl_hi_stable = scl_lvl_i & ~edge_i[SCL];
    start         = fall_i[SDA] & scl_hi_stable;
    stop          = rise_i[SDA] & scl_hi_stable;
  end

  always_comb begin
    hits_o = '0;
    if (rise_i[SCL]) begin
      hits_o[V_LOW] = scl_len < lim.lo;
      hits_o[V_DSU] = dsu_len < lim.setup_dat;
    end
    if (fall_i[SCL]) begin
      hits_o[V_HIGH] = scl_len < lim.hi;
      hits_o[V_HOLD] = pend_q && (sda_len < lim.hold_sta);
    end
    if (start) begin
      hits_o[V_RSU]  = scl_len < lim.setup_sta;
      hits_o[V_FREE] = free_q && (sda_len < lim.free);
    end
    if (stop) hits_o[V_PSU] = scl_len < lim.setup_sto;
  end

  always_comb begin
    st_en  = start | stop | fall_i[SCL];
    free_d = free_q;
    pend_d = pend_q;
    if (start) begin
      free_d = 1'b0;
      pend_d = 1'b1;
    end
    if (stop) begin
      free_d = 1'b1;
      pend_d = 1'b0;
    end
    if (fall_i[SCL]) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= 1'b1;
      pend_q <= 1'b0;
    end else if (st_en) begin
      free_q <= free_d;
      pend_q <= pend_d;
    end
  end

  // R2
  low_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hits_o[V_LOW] |-> rise_i[SCL]);

  // R5
  hold_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hits_o[V_HOLD] |-> pend_q);

  // R4
  gap_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hits_o[V_FREE] |-> free_q);

  // R7
  stop_marks_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hits_o[V_PSU] |=> free_q);

endmodule

// File: rtl/i2c_timing_monitor.sv
module i2c_timing_monitor
  import i2c_tmon_pkg::*;
#(
  parameter int unsigned CLK_PS = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          hs_mode_i,
  input  logic          clr_i,
  output logic [NV-1:0] viol_sticky_o,
  output logic [NV-1:0] viol_pulse_o
);

  localparam limits_t     LIM_FS  = make_limits(1'b0, CLK_PS);
  localparam limits_t     LIM_HS  = make_limits(1'b1, CLK_PS);
  localparam int unsigned LONGEST = ns2cyc(FS_LOW_NS, CLK_PS);
  localparam int          CNT_W   = $clog2(LONGEST + 1) + 1;

  logic [1:0]            rst_pipe;
  logic                  rst_core_n;
  logic [1:0]            lvl_s, edge_w, rise_w, fall_w;
  logic [1:0][CNT_W-1:0] run_w;
  logic [NV-1:0]         hits;
  logic [NV-1:0]         sticky_q, sticky_d, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  i2c_tmon_sync #(.W(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   ({sda_i, scl_i}),
    .q_o   (lvl_s)
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_run
      i2c_tmon_run #(.CNT_W(CNT_W)) u_run (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .lvl_i  (lvl_s[g]),
        .edge_o (edge_w[g]),
        .rise_o (rise_w[g]),
        .fall_o (fall_w[g]),
        .run_o  (run_w[g])
      );
    end
  endgenerate

  i2c_tmon_rules #(.CNT_W(CNT_W), .LIM_FS(LIM_FS), .LIM_HS(LIM_HS)) u_rules (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .hs_mode_i (hs_mode_i),
    .scl_lvl_i (lvl_s[SCL]),
    .edge_i    (edge_w),
    .rise_i    (rise_w),
    .fall_i    (fall_w),
    .run_i     (run_w),
    .hits_o    (hits)
  );

  always_comb sticky_d = hits | (clr_i ? '0 : sticky_q);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sticky_q <= '0;
      pulse_q  <= '0;
    end else begin
      sticky_q <= sticky_d;
      pulse_q  <= hits;
    end
  end

  assign viol_sticky_o = sticky_q;
  assign viol_pulse_o  = pulse_q;

  // R11
  pulse_in_sticky_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((viol_sticky_o & viol_pulse_o) == viol_pulse_o));

  // R10
  clear_wipes_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    clr_i |=> (viol_sticky_o == viol_pulse_o));

  // R10
  sticky_keeps_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !clr_i |=> ((viol_sticky_o & $past(viol_sticky_o)) == $past(viol_sticky_o)));

endmodule

// File: tb/sim_i2c_timing_monitor.sv
`timescale 1ns/1ps
module sim_i2c_timing_monitor;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, hs = 1'b0, clr = 1'b0;
  logic [6:0] sticky, pulse;

  always #10 clk = ~clk;

  i2c_timing_monitor #(.CLK_PS(20000)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .hs_mode_i(hs),
    .clr_i(clr), .viol_sticky_o(sticky), .viol_pulse_o(pulse)
  );

  int checks = 0;
  int fails = 0;
  int low_pulses = 0;
  int lim_f[7];
  int lim_h[7];

  // reference model state
  bit m_on = 1'b0;
  bit m_scl = 1'b1, m_sda = 1'b1, m_free = 1'b1, m_pend = 1'b0;
  int l_scl = 1000000, l_sda = 1000000;
  logic [6:0] d1 = '0, d2 = '0, e_pulse = '0, e_sticky = '0;

  function automatic int cyc(input int ns);
    return (ns * 1000 + 19999) / 20000;
  endfunction

  function automatic string req_of(input int b);
    case (b)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    if (m_on) begin
      bit se, de, sh;
      int lim[7];
      logic [6:0] h;
      h = '0;
      for (int i = 0; i < 7; i++) lim[i] = hs ? lim_h[i] : lim_f[i];
      se = (scl != m_scl);
      de = (sda != m_sda);
      sh = scl && m_scl;
      if (de && sh && !sda) begin
        if (l_scl < lim[4]) h[4] = 1'b1;
        if (m_free && l_sda < lim[2]) h[2] = 1'b1;
        m_free = 1'b0; m_pend = 1'b1;
      end
      if (de && sh && sda) begin
        if (l_scl < lim[5]) h[5] = 1'b1;
        m_free = 1'b1; m_pend = 1'b0;
      end
      if (se && scl) begin
        if (l_scl < lim[0]) h[0] = 1'b1;
        if ((de ? 0 : l_sda) < lim[6]) h[6] = 1'b1;
      end
      if (se && !scl) begin
        if (l_scl < lim[1]) h[1] = 1'b1;
        if (m_pend && l_sda < lim[3]) h[3] = 1'b1;
        m_pend = 1'b0;
      end
      l_scl = se ? 1 : l_scl + 1;
      l_sda = de ? 1 : l_sda + 1;
      m_scl = scl; m_sda = sda;
      e_pulse = d2;
      e_sticky = clr ? d2 : (e_sticky | d2);
      d2 = d1; d1 = h;
    end
  end

  // per-cycle comparison against the model (R10, R11 and the rule bits)
  always @(negedge clk) begin
    if (m_on) begin
      logic [6:0] dp, ds;
      int b;
      checks++;
      if (pulse[0] === 1'b1) low_pulses++;
      dp = pulse ^ e_pulse;
      ds = sticky ^ e_sticky;
      if (pulse !== e_pulse || sticky !== e_sticky) begin
        fails++;
        b = 0;
        for (int i = 6; i >= 0; i--) if (dp[i] !== 1'b0 || ds[i] !== 1'b0) b = i;
        $display("FAIL %s/R11 bit %0d: pulse actual=%b expected=%b, sticky actual=%b expected=%b",
                 (dp[b] !== 1'b0) ? req_of(b) : "R10", b, pulse, e_pulse, sticky, e_sticky);
      end
    end
  end

  task automatic drive(input logic c, input logic d, input int n);
    scl = c; sda = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int lo, input int hi, input int su, input int hd,
                      input int sto, input int fre, input int sta);
    drive(1, 0, hd);
    drive(0, 0, lo - su); drive(0, 1, su); drive(1, 1, hi);
    drive(0, 1, lo - su); drive(0, 0, su); drive(1, 0, hi);
    drive(0, 0, lo - su); drive(0, 1, su); drive(1, 1, sta);
    drive(1, 0, hd);
    drive(0, 0, lo); drive(1, 0, sto);
    drive(1, 1, fre);
  endtask

  task automatic expect_sticky(input logic [6:0] e, input string r);
    checks++;
    if (sticky !== e) begin
      fails++;
      $display("FAIL %s sticky actual=%b expected=%b", r, sticky, e);
    end
  endtask

  task automatic gap_clear(input logic [6:0] e, input string r);
    drive(1, 1, 40);
    expect_sticky(e, r);
    drive(1, 1, 100);
    expect_sticky(e, "R10 hold");
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    drive(1, 1, 4);
    expect_sticky('0, "R10 clear");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    lim_f = '{cyc(1300), cyc(600), cyc(600), cyc(100), cyc(100), cyc(100), cyc(100)};
    lim_h = '{cyc(160), cyc(60), cyc(160), cyc(100), cyc(100), cyc(100), cyc(10)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    // R1 reset state
    expect_sticky('0, "R1");
    checks++;
    if (pulse !== '0) begin
      fails++;
      $display("FAIL R1 pulse actual=%b expected=0000000", pulse);
    end
    m_on = 1'b1;
    drive(1, 1, 20);

    // R13 fast boundary frame: exact rounded limits pass
    xfer(65, 30, 5, 5, 5, 30, 25);
    gap_clear('0, "R13");
    // R2 low one short; R11 four separate pulses
    low_pulses = 0;
    xfer(64, 30, 5, 5, 5, 30, 25);
    gap_clear(7'b0000001, "R2");
    checks++;
    if (low_pulses != 4) begin
      fails++;
      $display("FAIL R11 pulse count actual=%0d expected=4", low_pulses);
    end
    // R3
    xfer(65, 29, 5, 5, 5, 30, 25);
    gap_clear(7'b0000010, "R3");
    // R8
    xfer(65, 30, 4, 5, 5, 30, 25);
    gap_clear(7'b1000000, "R8");
    // R5
    xfer(65, 30, 5, 4, 5, 30, 26);
    gap_clear(7'b0001000, "R5");
    // R7
    xfer(65, 30, 5, 5, 4, 30, 25);
    gap_clear(7'b0100000, "R7");
    // R6 (repeated start also shows no bus-free check, R4)
    xfer(65, 30, 5, 26, 5, 30, 4);
    gap_clear(7'b0010000, "R6");
    // R4 short free time before the next start
    xfer(65, 30, 5, 5, 5, 29, 25);
    xfer(65, 30, 5, 5, 5, 30, 25);
    gap_clear(7'b0000100, "R4");
    // R12 very long levels
    drive(1, 1, 600);
    drive(1, 0, 10); drive(0, 0, 400); drive(1, 0, 10); drive(1, 1, 40);
    gap_clear('0, "R12");

    // R9 high-speed mode
    hs = 1'b1;
    drive(1, 1, 20);
    xfer(8, 3, 1, 5, 5, 8, 5);
    gap_clear('0, "R9 hs boundary");
    xfer(8, 3, 0, 5, 5, 8, 5);
    gap_clear(7'b1000000, "R8 same-sample change");
    xfer(7, 3, 1, 5, 5, 8, 5);
    gap_clear(7'b0000001, "R2 hs");
    xfer(8, 3, 1, 5, 5, 7, 5);
    xfer(8, 3, 1, 5, 5, 8, 5);
    gap_clear(7'b0000100, "R4 hs");
    xfer(65, 30, 5, 5, 5, 30, 25);
    gap_clear('0, "R9 fast frame in hs");
    hs = 1'b0;
    drive(1, 1, 20);
    xfer(8, 3, 1, 5, 5, 8, 5);
    gap_clear(7'b1000011, "R9 hs frame in fast");

    drive(1, 1, 10);
    finish_run();
  end

endmodule